// File: doc/BRIEF.md
# Hop-Class Buffer Allocator

This block decides whether a packet arriving at a store-and-forward switching node gets a buffer slot. Slots are grouped into classes numbered 0 through N, where N is the longest hop count a route can have. Class 0 is a shared pool that any packet may use. Class k, for k of 1 or more, is held back for packets that have already crossed at least k links. This keeps room for packets close to their destination and so breaks the circular wait that causes store-and-forward deadlock.

A request carries the packet's hop count. In the same cycle the block either grants a slot and reports which class it came from, or drops the packet. When a port later sends a buffered packet on, it hands the class index back on the free interface, and that class's occupancy count goes down. The capacity of each class is set on an input vector, and the occupancy of every class is visible on an output vector. Payload storage, routing and scheduling are handled elsewhere.

Top module: `hop_pool_alloc`

## Requirements
- R1: After reset every class occupancy count reads zero.
- R2: A packet with hop count 0 may use only class 0, and it is granted class 0 whenever that class has room.
- R3: A granted packet with hop count h gets the lowest-numbered class in 0..h whose occupancy is below its capacity. `allocClass` carries that index, and the grant is combinational in the request cycle.
- R4: A request is dropped when every class from 0 to its clamped hop count is full. Each request raises exactly one of `allocGrant` and `allocDrop`. Neither is raised without `allocReq`.
- R5: A hop count above N is treated as N.
- R6: A grant raises the granted class's occupancy by one on the next clock edge.
- R7: A free lowers the named class's occupancy by one on the next edge. A free naming a class whose occupancy is zero has no effect.
- R8: A grant and a free for the same class in the same cycle leave that class's occupancy unchanged.
- R9: A class is full when its occupancy is at or above its capacity. A class with capacity 0 is never granted, and a grant never takes a class past its capacity. Capacity for class k sits in `capCfg[k*CNT_W +: CNT_W]`.
- R10: A stream of packets with hop count N fills the classes in order, from 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | A packet asks for a slot |
| allocHops | input | HOP_W | Links the packet has crossed |
| allocGrant | output | 1 | Slot granted this cycle |
| allocDrop | output | 1 | Packet dropped this cycle |
| allocClass | output | CLS_W | Class index of the granted slot |
| freeReq | input | 1 | A slot is returned |
| freeClass | input | CLS_W | Class the returned slot belongs to |
| capCfg | input | (N+1)*CNT_W | Capacity of each class, with class k at bits k*CNT_W |
| occupancy | output | (N+1)*CNT_W | Occupancy of each class, in the same packing |

## Verification
The properties assume three things about the inputs. A free names a class from 0 to N. Capacities stay below the counter's full range. The hop count and free inputs hold steady through each cycle. The stimulus meets these by driving every input half a cycle away from the active edge, and by keeping capacity values small (at most 2) in a 3-bit field. Frees are drawn freely over the valid class indices, so frees aimed at empty classes do occur, and they must be absorbed by the guard against going below zero rather than by the stimulus. Capacities change only in idle cycles, so no property sees a limit move under a grant in flight.

// File: rtl/hop_pool_pkg.sv
package hop_pool_pkg;
  // width of class indices carried in the strobe bundle (supports up to 16 classes)
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             incEn;
    logic [IDX_W-1:0] incCls;
    logic             decEn;
    logic [IDX_W-1:0] decCls;
  } poolStrobe_t;
endpackage

// File: rtl/hop_pool_ctrl.sv
module hop_pool_ctrl
  import hop_pool_pkg::*;
#(
  parameter int NUM_HOPS = 3,
  parameter int HOP_W    = 3,
  parameter int NCLS     = NUM_HOPS + 1,
  parameter int CLS_W    = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic             allocReq,
  input  logic [HOP_W-1:0] allocHops,
  input  logic             freeReq,
  input  logic [CLS_W-1:0] freeClass,
  input  logic [NCLS-1:0]  fullVec,
  input  logic [NCLS-1:0]  emptyVec,
  output logic             allocGrant,
  output logic             allocDrop,
  output logic [CLS_W-1:0] allocClass,
  output poolStrobe_t      strobe
);
  logic [NCLS-1:0] eligible;
  logic [CLS_W-1:0] pick;
  logic found;
  logic freeOk;
  int hopsClamped;

  // clamp the hop count to the deepest reserved level
  always_comb begin
    if (int'(allocHops) > NUM_HOPS) hopsClamped = NUM_HOPS;
    else                            hopsClamped = int'(allocHops);
  end

  // a class is eligible when the packet has travelled far enough and it has room
  for (genvar g = 0; g < NCLS; g++) begin : g_elig
    assign eligible[g] = (g <= hopsClamped) && !fullVec[g];
  end

  // lowest eligible class wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NCLS; k++) begin
      if (!found && eligible[k]) begin
        pick  = CLS_W'(k);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    freeOk = 1'b0;
    if (freeReq && (int'(freeClass) < NCLS)) freeOk = !emptyVec[freeClass];
  end

  assign allocGrant = allocReq && found;
  assign allocDrop  = allocReq && !found;
  assign allocClass = pick;

  always_comb begin
    strobe.incEn  = allocGrant;
    strobe.incCls = IDX_W'(pick);
    strobe.decEn  = freeOk;
    strobe.decCls = IDX_W'(freeClass);
  end
endmodule

// File: rtl/hop_pool_dp.sv
module hop_pool_dp
  import hop_pool_pkg::*;
#(
  parameter int NCLS  = 4,
  parameter int CNT_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  poolStrobe_t           strobe,
  input  logic [NCLS*CNT_W-1:0] capCfg,
  output logic [NCLS*CNT_W-1:0] occOut,
  output logic [NCLS-1:0]       fullVec,
  output logic [NCLS-1:0]       emptyVec
);
  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    logic [CNT_W-1:0] cnt;
    logic incHere;
    logic decHere;

    assign incHere = strobe.incEn && (strobe.incCls == IDX_W'(g));
    assign decHere = strobe.decEn && (strobe.decCls == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else begin
        case ({incHere, decHere})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign fullVec[g]  = (cnt >= capCfg[g*CNT_W +: CNT_W]);
    assign emptyVec[g] = (cnt == '0);
    assign occOut[g*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/hop_pool_alloc.sv
module hop_pool_alloc
  import hop_pool_pkg::*;
#(
  parameter int NUM_HOPS = 3,
  parameter int HOP_W    = 3,
  parameter int CNT_W    = 3,
  localparam int NCLS    = NUM_HOPS + 1,
  localparam int CLS_W   = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocReq,
  input  logic [HOP_W-1:0]      allocHops,
  output logic                  allocGrant,
  output logic                  allocDrop,
  output logic [CLS_W-1:0]      allocClass,
  input  logic                  freeReq,
  input  logic [CLS_W-1:0]      freeClass,
  input  logic [NCLS*CNT_W-1:0] capCfg,
  output logic [NCLS*CNT_W-1:0] occupancy
);
  poolStrobe_t strobe;
  logic [NCLS-1:0] fullVec;
  logic [NCLS-1:0] emptyVec;

  hop_pool_ctrl #(
    .NUM_HOPS(NUM_HOPS), .HOP_W(HOP_W), .NCLS(NCLS), .CLS_W(CLS_W)
  ) u_ctrl (
    .allocReq  (allocReq),
    .allocHops (allocHops),
    .freeReq   (freeReq),
    .freeClass (freeClass),
    .fullVec   (fullVec),
    .emptyVec  (emptyVec),
    .allocGrant(allocGrant),
    .allocDrop (allocDrop),
    .allocClass(allocClass),
    .strobe    (strobe)
  );

  hop_pool_dp #(
    .NCLS(NCLS), .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .capCfg  (capCfg),
    .occOut  (occupancy),
    .fullVec (fullVec),
    .emptyVec(emptyVec)
  );
endmodule

// File: rtl/hop_pool_chk.sv
module hop_pool_chk #(
  parameter int NUM_HOPS = 3,
  parameter int HOP_W    = 3,
  parameter int CNT_W    = 3,
  localparam int NCLS    = NUM_HOPS + 1,
  localparam int CLS_W   = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  allocReq,
  input logic [HOP_W-1:0]      allocHops,
  input logic                  allocGrant,
  input logic                  allocDrop,
  input logic [CLS_W-1:0]      allocClass,
  input logic                  freeReq,
  input logic [CLS_W-1:0]      freeClass,
  input logic [NCLS*CNT_W-1:0] capCfg,
  input logic [NCLS*CNT_W-1:0] occupancy
);
  logic [CNT_W-1:0] occArr [NCLS];
  logic [CNT_W-1:0] capArr [NCLS];
  for (genvar g = 0; g < NCLS; g++) begin : g_unpack
    assign occArr[g] = occupancy[g*CNT_W +: CNT_W];
    assign capArr[g] = capCfg[g*CNT_W +: CNT_W];
  end

  logic [CNT_W-1:0] selOcc;
  logic [CNT_W-1:0] freeOcc;
  assign selOcc  = occArr[allocClass];
  assign freeOcc = occArr[freeClass];

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocReq |-> ($countones({allocGrant, allocDrop}) == 1));

  // R4
  no_outcome_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !allocReq |-> (!allocGrant && !allocDrop));

  // R3 R5
  class_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> ((int'(allocClass) <= int'(allocHops)) && (int'(allocClass) <= NUM_HOPS)));

  // R9
  grant_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> (selOcc < capArr[allocClass]));

  // R2
  drop_pool_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocDrop |-> (occArr[0] >= capArr[0]));

  // R6
  grant_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocGrant && !(freeReq && freeClass == allocClass))
      |=> (occArr[$past(allocClass)] == CNT_W'($past(selOcc) + 1'b1)));

  // R8
  same_cls_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocGrant && freeReq && freeClass == allocClass && freeOcc != '0)
      |=> (occArr[$past(allocClass)] == $past(selOcc)));

  // R7
  free_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freeReq && freeOcc == '0 && !(allocGrant && allocClass == freeClass))
      |=> (occArr[$past(freeClass)] == '0));
endmodule

bind hop_pool_alloc hop_pool_chk #(
  .NUM_HOPS(NUM_HOPS), .HOP_W(HOP_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .allocReq  (allocReq),
  .allocHops (allocHops),
  .allocGrant(allocGrant),
  .allocDrop (allocDrop),
  .allocClass(allocClass),
  .freeReq   (freeReq),
  .freeClass (freeClass),
  .capCfg    (capCfg),
  .occupancy (occupancy)
);

// File: tb/hop_pool_alloc_bench.sv
`timescale 1ns/1ps
module hop_pool_alloc_bench;
  localparam int N     = 3;
  localparam int HOP_W = 3;
  localparam int CNT_W = 3;
  localparam int NCLS  = N + 1;
  localparam int CLS_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocReq = 1'b0;
  logic [HOP_W-1:0] allocHops = '0;
  logic allocGrant, allocDrop;
  logic [CLS_W-1:0] allocClass;
  logic freeReq = 1'b0;
  logic [CLS_W-1:0] freeClass = '0;
  logic [NCLS*CNT_W-1:0] capCfg = '0;
  logic [NCLS*CNT_W-1:0] occupancy;

  int checks = 0;
  int fails = 0;
  int cnt [NCLS];
  int capM [NCLS];

  always #2.5 clk = ~clk;

  hop_pool_alloc #(.NUM_HOPS(N), .HOP_W(HOP_W), .CNT_W(CNT_W)) u_hop_pool_alloc (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocHops(allocHops),
    .allocGrant(allocGrant), .allocDrop(allocDrop), .allocClass(allocClass),
    .freeReq(freeReq), .freeClass(freeClass), .capCfg(capCfg), .occupancy(occupancy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int occOf(input int k);
    return int'(occupancy[k*CNT_W +: CNT_W]);
  endfunction

  task automatic setCaps(input int c0, input int c1, input int c2, input int c3);
    @(negedge clk);
    allocReq = 1'b0; freeReq = 1'b0;
    capM[0] = c0; capM[1] = c1; capM[2] = c2; capM[3] = c3;
    for (int k = 0; k < NCLS; k++) capCfg[k*CNT_W +: CNT_W] = CNT_W'(capM[k]);
  endtask

  task automatic doCycle(input bit aReq, input int h, input bit fReq, input int fc, input string tag);
    int hc;
    int expCls;
    bit expGrant;
    bit doDec;
    string t;
    @(negedge clk);
    allocReq = aReq; allocHops = HOP_W'(h); freeReq = fReq; freeClass = CLS_W'(fc);
    #1;
    hc = (h > N) ? N : h;
    expCls = -1;
    for (int k = 0; k <= hc; k++) if (expCls < 0 && cnt[k] < capM[k]) expCls = k;
    expGrant = aReq && (expCls >= 0);
    if (aReq) begin
      t = expGrant ? tag : "R4";
      chk(allocGrant == expGrant && allocDrop == !expGrant, t,
          {allocGrant, allocDrop}, {expGrant, !expGrant});
      if (expGrant) chk(int'(allocClass) == expCls, tag, int'(allocClass), expCls);
    end else begin
      chk(!allocGrant && !allocDrop, "R4", {allocGrant, allocDrop}, 0);
    end
    doDec = fReq && cnt[fc] > 0;
    @(posedge clk);
    #1;
    if (expGrant) cnt[expCls]++;
    if (doDec) cnt[fc]--;
    if (fReq && expGrant && fc == expCls) t = "R8";
    else if (fReq) t = "R7";
    else t = "R6";
    for (int k = 0; k < NCLS; k++) chk(occOf(k) == cnt[k], t, occOf(k), cnt[k]);
  endtask

  task automatic drainAll();
    for (int k = 0; k < NCLS; k++)
      while (cnt[k] > 0) doCycle(0, 0, 1, k, "R7");
  endtask

  task automatic fillWith(input int h, input string tag);
    for (int i = 0; i < 8; i++) begin
      doCycle(1, h, 0, 0, tag);
      if (allocDrop) break;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCLS; k++) cnt[k] = 0;
    setCaps(2, 1, 2, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int k = 0; k < NCLS; k++) chk(occOf(k) == 0, "R1", occOf(k), 0);

    // R2: hop 0 uses only the common pool
    fillWith(0, "R2");
    drainAll();
    // R3: intermediate hop counts
    for (int h = 1; h < N; h++) begin
      fillWith(h, "R3");
      drainAll();
    end
    // R10: hop N fills 0 upward
    fillWith(N, "R10");
    drainAll();
    // R5: hop counts above N behave as N
    for (int h = N + 1; h < (1 << HOP_W); h++) begin
      fillWith(h, "R5");
      drainAll();
    end
    // R3: stacked fill, low hops first then deeper ones
    for (int h = 0; h <= N; h++) fillWith(h, "R3");
    drainAll();

    // R7: free to empty classes is ignored
    for (int k = 0; k < NCLS; k++) doCycle(0, 0, 1, k, "R7");

    // R8: same-class allocate and free
    doCycle(1, 0, 0, 0, "R8");
    doCycle(1, 0, 1, 0, "R8");
    chk(occOf(0) == 1, "R8", occOf(0), 1);
    drainAll();

    // R9: capacity zero class is skipped
    setCaps(1, 0, 2, 0);
    fillWith(1, "R9");
    fillWith(N, "R9");
    chk(occOf(1) == 0 && occOf(3) == 0, "R9", occOf(1) + occOf(3), 0);
    drainAll();

    // R3: mixed traffic
    setCaps(2, 1, 2, 1);
    for (int i = 0; i < 600; i++)
      doCycle(1'($urandom % 2), int'($urandom % 8), 1'($urandom % 2), int'($urandom % 4), "R3");
    drainAll();

    @(negedge clk);
    allocReq = 1'b0; freeReq = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule